// File: doc/BRIEF.md
# Reservation Station Array with Result Snooping

This block holds three waiting operations in front of a two-stage pipelined adder. An issue port places an operation into a chosen entry. Each of its two operands arrives either as a ready value or as the 4-bit tag of the unit that will later produce it. While an entry waits, it watches a shared result broadcast bus of tag plus data. When the bus carries the tag an operand is waiting for, the entry takes the data from the bus. An entry whose two operands both hold values is sent to the adder. The lowest-numbered ready entry goes first.

Two cycles after dispatch, the sum is parked in its entry and offered for broadcast under the entry's fixed tag. The entry is released when an external arbiter grants that offer. A full-station flag tells the issue logic to stall. The sum is an integer sum, wrapping modulo 2^16.

Top module: `rs_array`

## Requirements
- R1: Entries 0, 1 and 2 carry the fixed result tags 10, 11 and 12. Both `dispTag` and `resultTag` report the entry as that tag.
- R2: At issue, an operand whose tag is 0 is stored as a ready value. An operand with a nonzero tag stores that tag and waits.
- R3: A waiting operand captures `cdbData` when `cdbValid` is high and `cdbTag` equals its stored tag. A broadcast with any other tag leaves the entry waiting.
- R4: An entry is dispatched only when both operands hold values, and never in the cycle it is issued or the cycle a value is captured. The earliest dispatch is the following cycle.
- R5: When several entries are ready in one cycle, the lowest-numbered entry is dispatched. One entry is dispatched per cycle.
- R6: The adder accepts a dispatch every cycle. An operation dispatched in cycle D is offered on the result port in cycle D+2.
- R7: A broadcast in the same cycle as an issue is applied to the operands being issued. An operand issued with the broadcast tag is ready at once.
- R8: `resultData` equals (A + B) mod 2^16. Among finished entries the lowest-numbered one is offered. The offer holds until `resultGrant` is high, and the entry is then free from the next cycle.
- R9: Issue to a busy entry, or to slot value 3, is refused: `issueAccept` stays low and the entry's operation and operands are unchanged.
- R10: `stationFull` is high exactly when all three entries are occupied.
- R11: After reset all entries are free and `dispValid`, `resultValid` and `stationFull` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request |
| issueSlot | input | 2 | Target entry index |
| srcATag | input | 4 | Operand A producer tag, 0 = value present |
| srcAData | input | 16 | Operand A value |
| srcBTag | input | 4 | Operand B producer tag, 0 = value present |
| srcBData | input | 16 | Operand B value |
| issueAccept | output | 1 | Issue taken this cycle |
| stationFull | output | 1 | No entry is free |
| cdbValid | input | 1 | Broadcast bus carries a result |
| cdbTag | input | 4 | Broadcast producer tag |
| cdbData | input | 16 | Broadcast value |
| dispValid | output | 1 | An entry is dispatched to the adder this cycle |
| dispTag | output | 4 | Tag of the dispatched entry |
| resultValid | output | 1 | A finished result is offered |
| resultTag | output | 4 | Tag of the offered result |
| resultData | output | 16 | Offered sum |
| resultGrant | input | 1 | Arbiter takes the offered result |

## Verification
The hardest situation to reach is several entries becoming ready in the very same cycle. With a single issue port they cannot all be issued ready at once. The bench therefore parks all three entries waiting on one common tag. It then releases them together with a single broadcast, and checks three back-to-back dispatches in entry order followed by results held without grant. The same-cycle issue-and-broadcast case and the one-cycle residency after a capture are each placed on exact cycles with their own stimulus.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int RS_ENT      = 3;
  localparam int RS_IDX_W    = $clog2(RS_ENT + 1);
  localparam int RS_TAG_W    = 4;
  localparam int RS_DATA_W   = 16;
  localparam int RS_BASE_TAG = 10;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2,
    ST_DONE = 2'd3
  } entState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [RS_ENT-1:0]   issueWe;
    logic                dispGo;
    logic [RS_IDX_W-1:0] dispIdx;
    logic                wbGo;
    logic [RS_IDX_W-1:0] wbIdx;
    logic [RS_IDX_W-1:0] resIdx;
  } rsStrobe_t;
endpackage

// File: rtl/rs_operand_slot.sv
module rs_operand_slot #(
  parameter int TAG_W  = rs_pkg::RS_TAG_W,
  parameter int DATA_W = rs_pkg::RS_DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [TAG_W-1:0]  srcTag,
  input  logic [DATA_W-1:0] srcData,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbData,
  output logic [TAG_W-1:0]  curTag,
  output logic [DATA_W-1:0] curVal,
  output logic              ready
);
  logic srcHit;
  logic waitHit;

  assign srcHit  = cdbValid && (srcTag != '0) && (cdbTag == srcTag);
  assign waitHit = cdbValid && (curTag != '0) && (cdbTag == curTag);
  assign ready   = (curTag == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTag <= '0;
      curVal <= '0;
    end else if (load) begin
      if (srcTag == '0) begin
        curTag <= '0;
        curVal <= srcData;
      end else if (srcHit) begin
        curTag <= '0;
        curVal <= cdbData;
      end else begin
        curTag <= srcTag;
      end
    end else if (waitHit) begin
      curTag <= '0;
      curVal <= cdbData;
    end
  end

  a_r3_capture: assert property (@(posedge clk) disable iff (!rstN)
    (!load && waitHit) |=> (curTag == '0 && curVal == $past(cdbData)));

  a_r7_issue_bcast: assert property (@(posedge clk) disable iff (!rstN)
    (load && srcHit) |=> (curTag == '0 && curVal == $past(cdbData)));

  a_r2_wait_tag: assert property (@(posedge clk) disable iff (!rstN)
    (load && srcTag != '0 && !srcHit) |=> (curTag == $past(srcTag)));
endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pkg::*;
#(
  parameter int ENT    = RS_ENT,
  parameter int TAG_W  = RS_TAG_W,
  parameter int DATA_W = RS_DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  rsStrobe_t         strb,
  input  logic [TAG_W-1:0]  srcATag,
  input  logic [DATA_W-1:0] srcAData,
  input  logic [TAG_W-1:0]  srcBTag,
  input  logic [DATA_W-1:0] srcBData,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbData,
  output logic [ENT-1:0]    opReady,
  output logic [DATA_W-1:0] resultData
);
  logic [TAG_W-1:0]  aTag [ENT];
  logic [TAG_W-1:0]  bTag [ENT];
  logic [DATA_W-1:0] aVal [ENT];
  logic [DATA_W-1:0] bVal [ENT];
  logic [DATA_W-1:0] resVal [ENT];
  logic [ENT-1:0]    aRdy;
  logic [ENT-1:0]    bRdy;
  logic [DATA_W-1:0] pipeA;
  logic [DATA_W-1:0] pipeB;
  logic [DATA_W-1:0] selA;
  logic [DATA_W-1:0] selB;
  logic [DATA_W-1:0] selRes;

  for (genvar e = 0; e < ENT; e++) begin : g_ent
    rs_operand_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_opA (
      .clk(clk), .rstN(rstN), .load(strb.issueWe[e]),
      .srcTag(srcATag), .srcData(srcAData),
      .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData),
      .curTag(aTag[e]), .curVal(aVal[e]), .ready(aRdy[e])
    );
    rs_operand_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_opB (
      .clk(clk), .rstN(rstN), .load(strb.issueWe[e]),
      .srcTag(srcBTag), .srcData(srcBData),
      .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData),
      .curTag(bTag[e]), .curVal(bVal[e]), .ready(bRdy[e])
    );
    assign opReady[e] = aRdy[e] && bRdy[e];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        resVal[e] <= '0;
      end else if (strb.wbGo && strb.wbIdx == RS_IDX_W'(e)) begin
        resVal[e] <= pipeA + pipeB;
      end
    end
  end

  // operand and result multiplexers
  always_comb begin
    selA   = '0;
    selB   = '0;
    selRes = '0;
    for (int e = 0; e < ENT; e++) begin
      if (strb.dispIdx == RS_IDX_W'(e)) begin
        selA = aVal[e];
        selB = bVal[e];
      end
      if (strb.resIdx == RS_IDX_W'(e)) begin
        selRes = resVal[e];
      end
    end
  end

  // adder stage one: operand register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeA <= '0;
      pipeB <= '0;
    end else if (strb.dispGo) begin
      pipeA <= selA;
      pipeB <= selB;
    end
  end

  assign resultData = selRes;

  a_r10_single_issue: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.issueWe));
endmodule

// File: rtl/rs_control.sv
module rs_control
  import rs_pkg::*;
#(
  parameter int ENT      = RS_ENT,
  parameter int TAG_W    = RS_TAG_W,
  parameter int BASE_TAG = RS_BASE_TAG
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueValid,
  input  logic [RS_IDX_W-1:0] issueSlot,
  input  logic [ENT-1:0]      opReady,
  input  logic                resultGrant,
  output rsStrobe_t           strb,
  output logic                issueAccept,
  output logic                stationFull,
  output logic                dispValid,
  output logic [TAG_W-1:0]    dispTag,
  output logic                resultValid,
  output logic [TAG_W-1:0]    resultTag
);
  entState_t           entState [ENT];
  logic [ENT-1:0]      canGo;
  logic [ENT-1:0]      isDone;
  logic [ENT-1:0]      isBusy;
  logic                slotFree;
  logic                dispGo;
  logic [RS_IDX_W-1:0] dispIdx;
  logic                doneAny;
  logic [RS_IDX_W-1:0] doneIdx;
  logic                grantGo;
  logic                pipeV;
  logic [RS_IDX_W-1:0] pipeIdx;

  for (genvar e = 0; e < ENT; e++) begin : g_flags
    assign canGo[e]  = (entState[e] == ST_WAIT) && opReady[e];
    assign isDone[e] = (entState[e] == ST_DONE);
    assign isBusy[e] = (entState[e] != ST_FREE);
  end

  always_comb begin
    slotFree = 1'b0;
    for (int e = 0; e < ENT; e++) begin
      if (issueSlot == RS_IDX_W'(e) && !isBusy[e]) slotFree = 1'b1;
    end
  end

  assign issueAccept = issueValid && slotFree;
  assign stationFull = &isBusy;

  // lowest index wins: scan downward, last hit kept
  always_comb begin
    dispGo  = 1'b0;
    dispIdx = '0;
    doneAny = 1'b0;
    doneIdx = '0;
    for (int e = ENT - 1; e >= 0; e--) begin
      if (canGo[e]) begin
        dispGo  = 1'b1;
        dispIdx = RS_IDX_W'(e);
      end
      if (isDone[e]) begin
        doneAny = 1'b1;
        doneIdx = RS_IDX_W'(e);
      end
    end
  end

  assign grantGo = doneAny && resultGrant;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeV   <= 1'b0;
      pipeIdx <= '0;
    end else begin
      pipeV   <= dispGo;
      pipeIdx <= dispIdx;
    end
  end

  for (genvar e = 0; e < ENT; e++) begin : g_state
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entState[e] <= ST_FREE;
      end else if (issueAccept && issueSlot == RS_IDX_W'(e)) begin
        entState[e] <= ST_WAIT;
      end else if (dispGo && dispIdx == RS_IDX_W'(e)) begin
        entState[e] <= ST_EXEC;
      end else if (pipeV && pipeIdx == RS_IDX_W'(e)) begin
        entState[e] <= ST_DONE;
      end else if (grantGo && doneIdx == RS_IDX_W'(e)) begin
        entState[e] <= ST_FREE;
      end
    end
  end

  always_comb begin
    for (int e = 0; e < ENT; e++) begin
      strb.issueWe[e] = issueAccept && (issueSlot == RS_IDX_W'(e));
    end
  end
  assign strb.dispGo  = dispGo;
  assign strb.dispIdx = dispIdx;
  assign strb.wbGo    = pipeV;
  assign strb.wbIdx   = pipeIdx;
  assign strb.resIdx  = doneIdx;

  assign dispValid   = dispGo;
  assign dispTag     = TAG_W'(BASE_TAG + int'(dispIdx));
  assign resultValid = doneAny;
  assign resultTag   = TAG_W'(BASE_TAG + int'(doneIdx));

  a_r4_dispatch_ready: assert property (@(posedge clk) disable iff (!rstN)
    dispGo |-> opReady[dispIdx]);

  a_r6_pipe_follows: assert property (@(posedge clk) disable iff (!rstN)
    dispGo |=> (pipeV && pipeIdx == $past(dispIdx)));

  a_r8_offer_holds: assert property (@(posedge clk) disable iff (!rstN)
    (doneAny && !resultGrant) |=> doneAny);

  a_r9_full_refuses: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && stationFull) |-> !issueAccept);
endmodule

// File: rtl/rs_array.sv
module rs_array
  import rs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  input  logic [RS_IDX_W-1:0]  issueSlot,
  input  logic [RS_TAG_W-1:0]  srcATag,
  input  logic [RS_DATA_W-1:0] srcAData,
  input  logic [RS_TAG_W-1:0]  srcBTag,
  input  logic [RS_DATA_W-1:0] srcBData,
  output logic                 issueAccept,
  output logic                 stationFull,
  input  logic                 cdbValid,
  input  logic [RS_TAG_W-1:0]  cdbTag,
  input  logic [RS_DATA_W-1:0] cdbData,
  output logic                 dispValid,
  output logic [RS_TAG_W-1:0]  dispTag,
  output logic                 resultValid,
  output logic [RS_TAG_W-1:0]  resultTag,
  output logic [RS_DATA_W-1:0] resultData,
  input  logic                 resultGrant
);
  rsStrobe_t         strb;
  logic [RS_ENT-1:0] opReady;

  rs_control #(.ENT(RS_ENT), .TAG_W(RS_TAG_W), .BASE_TAG(RS_BASE_TAG)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueSlot(issueSlot),
    .opReady(opReady), .resultGrant(resultGrant),
    .strb(strb), .issueAccept(issueAccept), .stationFull(stationFull),
    .dispValid(dispValid), .dispTag(dispTag),
    .resultValid(resultValid), .resultTag(resultTag)
  );

  rs_datapath #(.ENT(RS_ENT), .TAG_W(RS_TAG_W), .DATA_W(RS_DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .srcATag(srcATag), .srcAData(srcAData),
    .srcBTag(srcBTag), .srcBData(srcBData),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData),
    .opReady(opReady), .resultData(resultData)
  );
endmodule

// File: tb/test_rs_array.sv
module test_rs_array;
  logic        clk = 1'b0;
  logic        rstN;
  logic        issueValid;
  logic [1:0]  issueSlot;
  logic [3:0]  srcATag;
  logic [15:0] srcAData;
  logic [3:0]  srcBTag;
  logic [15:0] srcBData;
  logic        issueAccept;
  logic        stationFull;
  logic        cdbValid;
  logic [3:0]  cdbTag;
  logic [15:0] cdbData;
  logic        dispValid;
  logic [3:0]  dispTag;
  logic        resultValid;
  logic [3:0]  resultTag;
  logic [15:0] resultData;
  logic        resultGrant;

  int nCmp = 0;
  int nBad = 0;

  always #4ns clk = ~clk;

  rs_array i_rs_array (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueSlot(issueSlot),
    .srcATag(srcATag), .srcAData(srcAData),
    .srcBTag(srcBTag), .srcBData(srcBData),
    .issueAccept(issueAccept), .stationFull(stationFull),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData),
    .dispValid(dispValid), .dispTag(dispTag),
    .resultValid(resultValid), .resultTag(resultTag),
    .resultData(resultData), .resultGrant(resultGrant)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    issueValid = 0; issueSlot = 0;
    srcATag = 0; srcAData = 0; srcBTag = 0; srcBData = 0;
    cdbValid = 0; cdbTag = 0; cdbData = 0; resultGrant = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic doIssue(input int slot, input int ta, input int da, input int tb, input int db);
    issueValid = 1; issueSlot = 2'(slot);
    srcATag = 4'(ta); srcAData = 16'(da);
    srcBTag = 4'(tb); srcBData = 16'(db);
  endtask

  task automatic bcast(input int t, input int d);
    cdbValid = 1; cdbTag = 4'(t); cdbData = 16'(d);
  endtask

  function automatic int wrapSum(input int a, input int b);
    return (a + b) & 16'hFFFF;
  endfunction

  // both operands ready at issue
  task automatic runReady(input int slot, input int a, input int b);
    doIssue(slot, 0, a, 0, b);
    #1;
    chk("R2 issue accepted", issueAccept, 1);
    chk("R4 no dispatch in issue cycle", dispValid, 0);
    step();
    #1;
    chk("R4 dispatch next cycle", dispValid, 1);
    chk("R1 dispatch tag", dispTag, 10 + slot);
    step();
    #1;
    chk("R6 no result at D+1", resultValid, 0);
    step();
    #1;
    chk("R6 result at D+2", resultValid, 1);
    chk("R1 result tag", resultTag, 10 + slot);
    chk("R8 sum", resultData, wrapSum(a, b));
    resultGrant = 1;
    step();
    #1;
    chk("R8 freed after grant", resultValid, 0);
    chk("R10 not full", stationFull, 0);
  endtask

  // operand A waits on a tag
  task automatic runSnoop(input int t, input int x, input int b);
    int slot;
    slot = t % 3;
    doIssue(slot, t, 16'h5A5A, 0, b);
    #1;
    chk("R2 waiting issue accepted", issueAccept, 1);
    step();
    bcast((t % 15) + 1, 16'hDEAD);
    #1;
    chk("R2 waiting entry not dispatched", dispValid, 0);
    step();
    bcast(t, x);
    #1;
    chk("R3 other tag ignored", dispValid, 0);
    step();
    #1;
    chk("R4 dispatch after capture", dispValid, 1);
    chk("R1 snoop dispatch tag", dispTag, 10 + slot);
    step();
    step();
    #1;
    chk("R3 captured sum", resultData, wrapSum(x, b));
    chk("R1 snoop result tag", resultTag, 10 + slot);
    resultGrant = 1;
    step();
  endtask

  initial begin
    #(8ns * 20000);
    nBad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    idle();
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    chk("R11 reset stationFull", stationFull, 0);
    chk("R11 reset resultValid", resultValid, 0);
    chk("R11 reset dispValid", dispValid, 0);
    step();

    // sweep of ready operands over all slots
    for (int k = 0; k < 24; k++) begin
      runReady(k % 3, (k * 4099 + 7) & 16'hFFFF, (65535 - k * 2311) & 16'hFFFF);
    end

    // sweep of waiting tags
    for (int t = 1; t < 16; t++) begin
      runSnoop(t, (t * 5171) & 16'hFFFF, (t * 911 + 60000) & 16'hFFFF);
    end

    // R7: issue and broadcast in the same cycle
    for (int k = 0; k < 3; k++) begin
      doIssue(2, 7, 0, 7, 0);
      bcast(7, 40000 + k * 1000);
      #1;
      chk("R7 accepted", issueAccept, 1);
      step();
      #1;
      chk("R7 ready at once", dispValid, 1);
      chk("R7 tag", dispTag, 12);
      step();
      step();
      #1;
      chk("R7 sum", resultData, wrapSum(40000 + k * 1000, 40000 + k * 1000));
      resultGrant = 1;
      step();
    end

    // R5/R9/R10: three entries released by one broadcast
    doIssue(2, 3, 0, 0, 300);
    step();
    doIssue(1, 3, 0, 0, 200);
    #1;
    chk("R10 two busy not full", stationFull, 0);
    step();
    doIssue(0, 3, 0, 0, 100);
    step();
    #1;
    chk("R10 full", stationFull, 1);
    doIssue(1, 0, 1, 0, 1);
    #1;
    chk("R9 busy slot refused", issueAccept, 0);
    step();
    doIssue(3, 0, 1, 0, 1);
    #1;
    chk("R9 slot 3 refused", issueAccept, 0);
    chk("R9 refused issue no dispatch", dispValid, 0);
    step();
    bcast(3, 1000);
    #1;
    chk("R4 no dispatch in capture cycle", dispValid, 0);
    step();
    #1;
    chk("R5 first dispatch", dispTag, 10);
    step();
    #1;
    chk("R6 back-to-back dispatch", dispValid, 1);
    chk("R5 second dispatch", dispTag, 11);
    step();
    #1;
    chk("R5 third dispatch", dispTag, 12);
    chk("R8 lowest finished offered", resultTag, 10);
    chk("R8 entry0 sum", resultData, 1100);
    step();
    #1;
    chk("R8 offer held", resultValid, 1);
    chk("R8 held tag", resultTag, 10);
    step();
    #1;
    chk("R8 still held", resultTag, 10);
    resultGrant = 1;
    step();
    #1;
    chk("R8 next offer", resultTag, 11);
    chk("R9 busy slot unchanged", resultData, 1200);
    chk("R10 free after grant", stationFull, 0);
    resultGrant = 1;
    step();
    #1;
    chk("R8 last offer", resultTag, 12);
    chk("R8 entry2 sum", resultData, 1300);
    resultGrant = 1;
    step();
    #1;
    chk("R8 all drained", resultValid, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule